// File: doc/BRIEF.md
# Converter Power-Mode Command Controller

This block sequences power and command state for a low-power delta-sigma converter. After a power-on reset it keeps the converter held while it counts master-clock cycles. It then waits in an idle command state with the analog section powered but the decimation filter stopped. Command bytes arrive already decoded from a serial port. They start conversions, put the converter into one of two low-power modes, or wake it again.

The two low-power modes differ in one way only. Sleep also stops the oscillator, and standby keeps it running. That choice, together with a strap that says whether the master clock comes from a crystal or from an external source, sets how a wake behaves. Leaving standby, or leaving sleep with an external clock, costs a fixed delay counted in clock cycles. Leaving sleep with a crystal waits until the oscillator reports that it is ready.

Commands enter on a valid/ready port. A byte is taken only on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low only while the power-on hold is active. There is no back-pressure at any other time: bytes that have no meaning in the current state are accepted and dropped. The enable and status outputs are plain levels.

Top module: `pwr_cmd_ctrl`

## Requirements
- R1: After `rst` is released, `por_hold` stays high for exactly POR_CYCLES rising edges. During that time `cmd_ready`, `analog_en` and `filter_en` are low and `osc_en` is high.
- R2: When the hold ends the block enters the idle command state. There `analog_en` and `osc_en` are high and `filter_en` is low until an accepted command changes the state.
- R3: An accepted byte with upper nibble 0xC in the idle state starts conversion. `filter_en` is high from the next cycle.
- R4: An accepted byte with upper nibble 0xA in the idle or converting state enters sleep in the next cycle, with `analog_en`, `osc_en` and `filter_en` all low. The lower nibble has no effect.
- R5: An accepted byte with upper nibble 0xB in the idle or converting state enters standby in the next cycle, with `analog_en` and `filter_en` low and `osc_en` high. The lower nibble has no effect.
- R6: In sleep or standby, only an upper nibble of 0xC leaves the mode. A sleep, standby or unlisted byte leaves every output unchanged.
- R7: A 0xC byte in standby, or in sleep with `xtal_sel` low, raises `analog_en` and `wake_busy` for exactly WAKE_CYCLES cycles with `filter_en` low. After that `filter_en` is high and `wake_busy` is low.
- R8: A 0xC byte in sleep with `xtal_sel` high raises `osc_en`, `analog_en` and `wake_busy`, which stay high until `osc_ready` is sampled high on a rising edge. From the next cycle `filter_en` is high and `wake_busy` is low.
- R9: Bytes accepted while `wake_busy` is high have no effect.
- R10: Bytes whose upper nibble is not 0xA, 0xB or 0xC are ignored in every state. A 0xC byte while converting is ignored as well.
- R11: `cmd_ready` is high in every state other than the power-on hold.
- R12: `rst` high on a rising edge returns the block to the power-on hold from any state and restarts the hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on emulation |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Block accepts command bytes |
| cmd_byte | input | 8 | Decoded command byte from the serial port |
| xtal_sel | input | 1 | Clock-source strap: 1 = crystal, 0 = external clock |
| osc_ready | input | 1 | Oscillator start-up complete (crystal wake) |
| por_hold | output | 1 | Converter held in power-on reset |
| wake_busy | output | 1 | A wake delay or oscillator wait is running |
| analog_en | output | 1 | Analog section power enable |
| osc_en | output | 1 | Oscillator enable |
| filter_en | output | 1 | Decimation-filter engine enable |

## Verification
The bench builds the block with POR_CYCLES = 20 and WAKE_CYCLES = 6 rather than the silicon-scale defaults. With these values the exact length of the power-on hold and of the fixed wake delay can be counted edge by edge. The short counts also let thousands of random commands pass through every mode transition, including repeated resets in the middle of a wake and long crystal waits with a randomly timed `osc_ready`.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  typedef enum logic [2:0] {
    ST_POR      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_RUN      = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_STBY     = 3'd4,
    ST_WAKE_DLY = 3'd5,
    ST_WAKE_OSC = 3'd6
  } pwr_state_e;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_SLEEP = 2'd1,
    CK_STBY  = 2'd2,
    CK_CONV  = 2'd3
  } cmd_kind_e;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_cmd_pkg::*;
(
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output cmd_kind_e  kind_o
);

  always_comb begin
    kind_o = CK_NONE;
    if (take_i) begin
      casez (byte_i)
        8'b1010_????: kind_o = CK_SLEEP;
        8'b1011_????: kind_o = CK_STBY;
        8'b1100_????: kind_o = CK_CONV;
        default:      kind_o = CK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_cycle_timer.sv
module pwr_cycle_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (clear_i)
      count_q <= '0;
    else if (count_q != CNT_MAX)
      count_q <= count_q + 1'b1;
  end

  assign expired_o = (count_q == limit_i - 1'b1);

  assert_clear_restarts_R12: assert property (@(posedge clk)
    clear_i |=> (count_q == '0));

endmodule

// File: rtl/pwr_enable_map.sv
module pwr_enable_map
  import pwr_cmd_pkg::*;
(
  input  pwr_state_e state_i,
  output logic       hold_o,
  output logic       analog_o,
  output logic       osc_o,
  output logic       filter_o,
  output logic       busy_o
);

  always_comb begin
    hold_o   = 1'b0;
    analog_o = 1'b1;
    osc_o    = 1'b1;
    filter_o = 1'b0;
    busy_o   = 1'b0;
    unique case (state_i)
      ST_POR:      begin hold_o = 1'b1; analog_o = 1'b0; end
      ST_IDLE:     ;
      ST_RUN:      filter_o = 1'b1;
      ST_SLEEP:    begin analog_o = 1'b0; osc_o = 1'b0; end
      ST_STBY:     analog_o = 1'b0;
      ST_WAKE_DLY: busy_o = 1'b1;
      ST_WAKE_OSC: busy_o = 1'b1;
      default:     begin hold_o = 1'b1; analog_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/pwr_cmd_ctrl.sv
module pwr_cmd_ctrl
  import pwr_cmd_pkg::*;
#(
  parameter int POR_CYCLES  = 490,
  parameter int WAKE_CYCLES = 98
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  input  logic       xtal_sel,
  input  logic       osc_ready,
  output logic       por_hold,
  output logic       wake_busy,
  output logic       analog_en,
  output logic       osc_en,
  output logic       filter_en
);

  localparam int MAX_LIM = (POR_CYCLES > WAKE_CYCLES) ? POR_CYCLES : WAKE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  pwr_state_e state_q, state_n;
  cmd_kind_e  kind;
  logic       take;
  logic       tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  assign take = cmd_valid && cmd_ready;

  pwr_cmd_decode u_decode (
    .take_i (take),
    .byte_i (cmd_byte),
    .kind_o (kind)
  );

  assign tmr_limit = (state_q == ST_POR) ? CNT_W'(POR_CYCLES) : CNT_W'(WAKE_CYCLES);
  assign tmr_clr   = rst || (state_n != state_q);

  pwr_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .clear_i   (tmr_clr),
    .limit_i   (tmr_limit),
    .expired_o (tmr_done)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_POR: if (tmr_done) state_n = ST_IDLE;
      ST_IDLE, ST_RUN: begin
        if (kind == CK_SLEEP)                       state_n = ST_SLEEP;
        else if (kind == CK_STBY)                   state_n = ST_STBY;
        else if (kind == CK_CONV && state_q == ST_IDLE) state_n = ST_RUN;
      end
      ST_SLEEP: if (kind == CK_CONV) state_n = xtal_sel ? ST_WAKE_OSC : ST_WAKE_DLY;
      ST_STBY:  if (kind == CK_CONV) state_n = ST_WAKE_DLY;
      ST_WAKE_DLY: if (tmr_done)  state_n = ST_RUN;
      ST_WAKE_OSC: if (osc_ready) state_n = ST_RUN;
      default: state_n = ST_POR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_POR;
    else     state_q <= state_n;
  end

  pwr_enable_map u_map (
    .state_i  (state_q),
    .hold_o   (por_hold),
    .analog_o (analog_en),
    .osc_o    (osc_en),
    .filter_o (filter_en),
    .busy_o   (wake_busy)
  );

  assign cmd_ready = (state_q != ST_POR);

  assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    por_hold |-> (!cmd_ready && !analog_en && !filter_en && osc_en));

  assert_ready_outside_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !por_hold |-> cmd_ready);

  assert_sleep_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE || state_q == ST_RUN) && take && cmd_byte[7:4] == 4'hA)
      |=> (!analog_en && !osc_en && !filter_en));

  assert_standby_osc_on_R5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE || state_q == ST_RUN) && take && cmd_byte[7:4] == 4'hB)
      |=> (!analog_en && osc_en && !filter_en));

  assert_lowpower_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SLEEP || state_q == ST_STBY) && !(take && cmd_byte[7:4] == 4'hC))
      |=> $stable({analog_en, osc_en, filter_en, wake_busy}));

  assert_busy_blocks_filter_R7: assert property (@(posedge clk) disable iff (rst)
    wake_busy |-> !filter_en);

  assert_crystal_waits_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE_OSC && !osc_ready) |=> wake_busy);

  assert_reset_holds_R12: assert property (@(posedge clk)
    rst |=> por_hold);

endmodule

// File: tb/pwr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_cmd_ctrl_tb;

  localparam int POR_N  = 20;
  localparam int WAKE_N = 6;

  localparam int M_POR = 0, M_IDLE = 1, M_RUN = 2, M_SLEEP = 3,
                 M_STBY = 4, M_WDLY = 5, M_WOSC = 6;

  logic       clk = 1'b0;
  logic       rst, cmd_valid, xtal_sel, osc_ready;
  logic [7:0] cmd_byte;
  logic       cmd_ready, por_hold, wake_busy, analog_en, osc_en, filter_en;

  int tests = 0;
  int fails = 0;
  int m_state = M_POR;
  int m_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_cmd_ctrl #(.POR_CYCLES(POR_N), .WAKE_CYCLES(WAKE_N)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .xtal_sel(xtal_sel), .osc_ready(osc_ready),
    .por_hold(por_hold), .wake_busy(wake_busy), .analog_en(analog_en),
    .osc_en(osc_en), .filter_en(filter_en)
  );

  // Expected outputs {hold, ready, analog, osc, filter, busy}
  function automatic logic [5:0] exp_out(input int s);
    case (s)
      M_POR:   return 6'b100100;
      M_IDLE:  return 6'b011100;
      M_RUN:   return 6'b011110;
      M_SLEEP: return 6'b010000;
      M_STBY:  return 6'b010100;
      default: return 6'b011101;
    endcase
  endfunction

  function automatic string state_tag(input int s);
    case (s)
      M_POR:   return "R1";
      M_IDLE:  return "R2";
      M_RUN:   return "R3";
      M_SLEEP: return "R4";
      M_STBY:  return "R5";
      M_WDLY:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_edge();
    logic acc;
    logic [3:0] nib;
    acc = cmd_valid && (m_state != M_POR);
    nib = cmd_byte[7:4];
    if (rst) begin
      m_state = M_POR; m_cnt = 0;
    end else begin
      case (m_state)
        M_POR: if (m_cnt == POR_N - 1) begin m_state = M_IDLE; m_cnt = 0; end
               else m_cnt++;
        M_IDLE, M_RUN: if (acc) begin
          if (nib == 4'hA) m_state = M_SLEEP;
          else if (nib == 4'hB) m_state = M_STBY;
          else if (nib == 4'hC) m_state = M_RUN;
        end
        M_SLEEP: if (acc && nib == 4'hC) begin
          m_state = xtal_sel ? M_WOSC : M_WDLY; m_cnt = 0;
        end
        M_STBY: if (acc && nib == 4'hC) begin m_state = M_WDLY; m_cnt = 0; end
        M_WDLY: if (m_cnt == WAKE_N - 1) begin m_state = M_RUN; m_cnt = 0; end
                else m_cnt++;
        default: if (osc_ready) m_state = M_RUN;
      endcase
    end
  endtask

  task automatic check_now(input string tag);
    logic [5:0] act, exp;
    act = {por_hold, cmd_ready, analog_en, osc_en, filter_en, wake_busy};
    exp = exp_out(m_state);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hold,ready,analog,osc,filter,busy} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [7:0] b,
                      input logic x, input logic o, input string tag);
    rst = r; cmd_valid = v; cmd_byte = b; xtal_sel = x; osc_ready = o;
    @(posedge clk);
    model_edge();
    #1;
    check_now(tag == "" ? state_tag(m_state) : tag);
  endtask

  task automatic idle_steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic cmd(input logic [7:0] b, input logic x, input string tag);
    step(1'b0, 1'b1, b, x, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    int r;
    logic [3:0] nib;
    rst = 1'b1; cmd_valid = 1'b0; cmd_byte = 8'h00; xtal_sel = 1'b0; osc_ready = 1'b0;
    void'($urandom(32'd1234));
    #1;
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R12");
    step(1'b1, 1'b1, 8'hC0, 1'b0, 1'b0, "R12");

    // R1: hold length counted edge by edge, commands offered during hold are not taken (R11)
    n = 0;
    do begin
      step(1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, "R1");
      n++;
    end while (por_hold && n < 1000);
    tests++;
    if (n != POR_N) begin
      fails++;
      $display("FAIL R1: hold length actual=%0d expected=%0d", n, POR_N);
    end
    idle_steps(3, "R2");
    cmd(8'h35, 1'b0, "R10");
    cmd(8'hF0, 1'b0, "R10");
    cmd(8'hC7, 1'b0, "R3");
    cmd(8'hC0, 1'b0, "R10");
    cmd(8'hAF, 1'b0, "R4");
    cmd(8'hB0, 1'b0, "R6");
    cmd(8'hA3, 1'b0, "R6");
    cmd(8'h12, 1'b0, "R6");
    // R7: wake from sleep with external clock
    cmd(8'hC1, 1'b0, "R7");
    cmd(8'hA0, 1'b0, "R9");
    cmd(8'hB0, 1'b0, "R9");
    idle_steps(WAKE_N, "R7");
    cmd(8'hB9, 1'b0, "R5");
    cmd(8'hA0, 1'b0, "R6");
    cmd(8'hC0, 1'b1, "R7");
    idle_steps(WAKE_N + 1, "R7");
    // R8: wake from sleep with crystal, osc_ready late
    cmd(8'hA2, 1'b0, "R4");
    cmd(8'hCE, 1'b1, "R8");
    for (int i = 0; i < 30; i++) step(1'b0, i[0], 8'hB0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R8");
    idle_steps(2, "R8");
    // R12: reset in the middle of a wake restarts the hold
    cmd(8'hB0, 1'b0, "R5");
    cmd(8'hC0, 1'b0, "R7");
    idle_steps(2, "R7");
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R12");
    idle_steps(POR_N + 2, "R12");

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      r = $urandom_range(0, 99);
      if (r < 20) nib = 4'hC;
      else if (r < 35) nib = 4'hA;
      else if (r < 50) nib = 4'hB;
      else nib = 4'($urandom_range(0, 9));
      step($urandom_range(0, 399) == 0,
           $urandom_range(0, 99) < 40,
           {nib, 4'($urandom_range(0, 15))},
           $urandom_range(0, 1) == 1,
           $urandom_range(0, 99) < 8,
           "");
    end
    finish_run();
  end

endmodule